// File: doc/BRIEF.md
# Two-Register Cartridge Memory Mapper

This block sits between a host CPU's expansion bus and a flash plus SRAM pair on a plug-in cartridge. Two byte-wide control registers live in the I/O2 page. The bank register selects which 8k flash page appears in the $A000 block. The configuration register chooses what the other memory windows hold and can hide both registers until the next hardware reset.

The host-side decoder supplies one-hot region selects: the 3k low RAM area, BLK1, BLK2, BLK3, BLK5 ($A000) and the I/O2 page. It also supplies the byte offset within I/O2, the read/write line and the write data. The mapper answers with combinational chip enables, the SRAM write enable, the flash high address lines and an SRAM page number. When the host reads a control register, it also returns the read data.

Top module: `cart_mapper`

## Requirements
- R1: After reset, offset 0 (bank) reads $00 and offset 1 (configuration) reads $40. `flash_hi` is 0, and a read in BLK5 enables flash.
- R2: A write at I/O2 offset 0 loads the bank register, which drives `flash_hi[7:0]` (A20..A13) and reads back at offset 0.
- R3: Configuration bit 0 drives `flash_hi[8]` (A21).
- R4: With configuration bit 5 clear, reads in BLK5 enable flash and not SRAM. With bit 5 set, BLK5 enables SRAM with `sram_page` = 4 and never flash. Flash is never enabled on a write cycle.
- R5: While configuration bit 6 is set, `sram_we` stays low for every BLK5 access, whether RAM or ROM is mapped there. With bit 6 clear and bit 5 set, a BLK5 write asserts `sram_we`.
- R6: Configuration bit 3 is a master enable for the selectable RAM. With bit 3 set, bit 4 = 0 maps RAM into the 3k low area (`sram_page` = 0), and bit 4 = 1 maps it into BLK1 (`sram_page` = 1). The unselected area gets no enable. With bit 3 clear, neither area is enabled.
- R7: BLK2 and BLK3 always enable SRAM (`sram_page` 2 and 3), for reads and writes, whatever the configuration.
- R8: Once configuration bit 7 is written as 1, writes to both registers are ignored and register reads drive no data (`reg_rdata_oe` low). A hardware reset restores both registers to their R1 values.
- R9: I/O2 offsets other than 0 and 1 neither write a register nor return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; register writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_wdata | input | 8 | Write data from the CPU |
| reg_off | input | REG_AW | Byte offset within the I/O2 page |
| sel_io2 | input | 1 | I/O2 page selected |
| sel_ram123 | input | 1 | 3k low RAM area selected |
| sel_blk1 | input | 1 | BLK1 selected |
| sel_blk2 | input | 1 | BLK2 selected |
| sel_blk3 | input | 1 | BLK3 selected |
| sel_blk5 | input | 1 | BLK5 ($A000) selected |
| flash_ce | output | 1 | Flash chip enable (read cycles only) |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |
| flash_hi | output | 9 | Flash address A21..A13 |
| sram_page | output | 3 | 8k SRAM page for the active region |
| reg_rdata | output | 8 | Register read data |
| reg_rdata_oe | output | 1 | Register read data valid / drive enable |

## Verification
Nearly all faults in this block come from one of the two registers holding a wrong value. That value shows at the ports in the next probe: `flash_hi` carries the bank and the top address bit directly, and each configuration bit alters a chip enable or write enable within the same cycle of a suitable region access. A corrupted lockout bit is the slowest fault to surface. It only shows on a later register read, or on a write that should or should not have landed. For that reason, every register write in the bench is followed by a readback or a region probe before the next write.

// File: rtl/cart_mapper.sv
module cart_mapper #(
  parameter int          REG_AW  = 8,
  parameter logic [7:0]  BANK_RST = 8'h00,
  parameter logic [7:0]  CFG_RST  = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rw,
  input  logic [7:0]        cpu_wdata,
  input  logic [REG_AW-1:0] reg_off,
  input  logic              sel_io2,
  input  logic              sel_ram123,
  input  logic              sel_blk1,
  input  logic              sel_blk2,
  input  logic              sel_blk3,
  input  logic              sel_blk5,
  output logic              flash_ce,
  output logic              sram_ce,
  output logic              sram_we,
  output logic [8:0]        flash_hi,
  output logic [2:0]        sram_page,
  output logic [7:0]        reg_rdata,
  output logic              reg_rdata_oe
);

  logic [7:0] bank_q, cfg_q;
  logic       locked, hit_bank, hit_cfg, low_ram, blk1_ram, blk5_ram, ram_hit;

  assign locked   = cfg_q[7];
  assign hit_bank = sel_io2 && !locked && (reg_off == REG_AW'(0));
  assign hit_cfg  = sel_io2 && !locked && (reg_off == REG_AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_RST;
      cfg_q  <= CFG_RST;
    end else if (!cpu_rw) begin
      if (hit_bank) bank_q <= cpu_wdata;
      if (hit_cfg)  cfg_q  <= cpu_wdata;
    end
  end

  assign low_ram  = sel_ram123 && cfg_q[3] && !cfg_q[4];
  assign blk1_ram = sel_blk1   && cfg_q[3] &&  cfg_q[4];
  assign blk5_ram = sel_blk5   && cfg_q[5];
  assign ram_hit  = low_ram || blk1_ram || sel_blk2 || sel_blk3 || blk5_ram;

  assign flash_ce = sel_blk5 && !cfg_q[5] && cpu_rw;
  assign sram_ce  = ram_hit;
  assign sram_we  = ram_hit && !cpu_rw && !(sel_blk5 && cfg_q[6]);
  assign flash_hi = {cfg_q[0], bank_q};

  always_comb begin
    sram_page = 3'd0;
    if (sel_blk1)      sram_page = 3'd1;
    else if (sel_blk2) sram_page = 3'd2;
    else if (sel_blk3) sram_page = 3'd3;
    else if (sel_blk5) sram_page = 3'd4;
  end

  assign reg_rdata_oe = cpu_rw && (hit_bank || hit_cfg);
  assign reg_rdata    = !reg_rdata_oe ? 8'h00 : (hit_cfg ? cfg_q : bank_q);

endmodule

module cart_mapper_chk #(
  parameter int REG_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rw,
  input logic [7:0]        cpu_wdata,
  input logic [REG_AW-1:0] reg_off,
  input logic              sel_io2,
  input logic              sel_blk1,
  input logic              sel_blk5,
  input logic              flash_ce,
  input logic              sram_ce,
  input logic              sram_we,
  input logic [8:0]        flash_hi,
  input logic              reg_rdata_oe,
  input logic [7:0]        bank_q,
  input logic [7:0]        cfg_q
);

  a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_io2 && !cpu_rw && !cfg_q[7] && reg_off == REG_AW'(0)) |=> flash_hi[7:0] == $past(cpu_wdata));

  a_r4_one_device: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_ce && sram_ce));

  a_r4_no_flash_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rw |-> !flash_ce);

  a_r5_wp_blk5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_blk5 && cfg_q[6]) |-> !sram_we);

  a_r6_blk1_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_blk1 && sram_ce) |-> (cfg_q[3] && cfg_q[4]));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |=> (cfg_q[7] && $stable(bank_q) && $stable(cfg_q)));

  a_r8_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |-> !reg_rdata_oe);

endmodule

bind cart_mapper cart_mapper_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata),
  .reg_off(reg_off), .sel_io2(sel_io2), .sel_blk1(sel_blk1), .sel_blk5(sel_blk5),
  .flash_ce(flash_ce), .sram_ce(sram_ce), .sram_we(sram_we), .flash_hi(flash_hi),
  .reg_rdata_oe(reg_rdata_oe), .bank_q(bank_q), .cfg_q(cfg_q)
);

// File: tb/test_cart_mapper.sv
module test_cart_mapper;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, cpu_rw = 1'b1;
  logic [7:0] cpu_wdata = 8'h00, reg_off = 8'h00;
  logic       sel_io2 = 0, sel_ram123 = 0, sel_blk1 = 0, sel_blk2 = 0, sel_blk3 = 0, sel_blk5 = 0;
  logic       flash_ce, sram_ce, sram_we, reg_rdata_oe;
  logic [8:0] flash_hi;
  logic [2:0] sram_page;
  logic [7:0] reg_rdata;
  int n_vec = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_mapper i_cart_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata), .reg_off(reg_off),
    .sel_io2(sel_io2), .sel_ram123(sel_ram123), .sel_blk1(sel_blk1), .sel_blk2(sel_blk2),
    .sel_blk3(sel_blk3), .sel_blk5(sel_blk5), .flash_ce(flash_ce), .sram_ce(sram_ce),
    .sram_we(sram_we), .flash_hi(flash_hi), .sram_page(sram_page),
    .reg_rdata(reg_rdata), .reg_rdata_oe(reg_rdata_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_io2 = 0; sel_ram123 = 0; sel_blk1 = 0; sel_blk2 = 0; sel_blk3 = 0; sel_blk5 = 0;
    cpu_rw = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); idle(); sel_io2 = 1; cpu_rw = 0; reg_off = off; cpu_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic rd(input string req, input logic [7:0] off, input int exp_oe, input int exp_d);
    @(negedge clk); idle(); sel_io2 = 1; reg_off = off; #1;
    chk(req, reg_rdata_oe, exp_oe);
    if (exp_oe == 1) chk(req, reg_rdata, exp_d);
    idle();
  endtask

  // region: 0 low3k, 1 blk1, 2 blk2, 3 blk3, 4 blk5; result {flash_ce, sram_ce, sram_we, page}
  task automatic probe(input int region, input logic rw, output logic [5:0] r);
    @(negedge clk); idle(); cpu_rw = rw;
    case (region)
      0: sel_ram123 = 1; 1: sel_blk1 = 1; 2: sel_blk2 = 1; 3: sel_blk3 = 1; default: sel_blk5 = 1;
    endcase
    #1; r = {flash_ce, sram_ce, sram_we, sram_page};
    idle();
  endtask

  task automatic t_reset();
    logic [5:0] r;
    do_reset();
    rd("R1 bank", 8'd0, 1, 8'h00);
    rd("R1 cfg", 8'd1, 1, 8'h40);
    chk("R1 flash_hi", flash_hi, 0);
    probe(4, 1, r); chk("R1 blk5 rom", r[5:4], 2'b10);
  endtask

  task automatic t_bank();
    wr(8'd0, 8'hA5); chk("R2 hi", flash_hi, 9'h0A5); rd("R2 rb", 8'd0, 1, 8'hA5);
    wr(8'd0, 8'h3C); chk("R2 hi2", flash_hi, 9'h03C);
  endtask

  task automatic t_a21();
    wr(8'd1, 8'h41); chk("R3 a21 set", flash_hi, 9'h13C);
    wr(8'd1, 8'h40); chk("R3 a21 clr", flash_hi, 9'h03C);
  endtask

  task automatic t_blk5();
    logic [5:0] r;
    probe(4, 0, r); chk("R4 rom write no flash", r[5:4], 2'b00);
    wr(8'd1, 8'h20);
    probe(4, 1, r); chk("R4 ram read", r, 6'b010100);
    probe(4, 0, r); chk("R5 we open", r, 6'b011100);
  endtask

  task automatic t_wp();
    logic [5:0] r;
    wr(8'd1, 8'h60);
    probe(4, 0, r); chk("R5 wp ram", r, 6'b010100);
    wr(8'd1, 8'h40);
    probe(4, 0, r); chk("R5 wp rom", r[3], 1'b0);
  endtask

  task automatic t_layout();
    logic [5:0] r;
    wr(8'd1, 8'h08);
    probe(0, 0, r); chk("R6 low on", r, 6'b011000);
    probe(1, 1, r); chk("R6 blk1 off", r[4], 1'b0);
    wr(8'd1, 8'h18);
    probe(1, 0, r); chk("R6 blk1 on", r, 6'b011001);
    probe(0, 1, r); chk("R6 low off", r[4], 1'b0);
    wr(8'd1, 8'h10);
    probe(1, 1, r); chk("R6 master off blk1", r[4], 1'b0);
    wr(8'd1, 8'h00);
    probe(0, 1, r); chk("R6 master off low", r[4], 1'b0);
  endtask

  task automatic t_always();
    logic [5:0] r;
    probe(2, 0, r); chk("R7 blk2", r, 6'b011010);
    probe(3, 1, r); chk("R7 blk3", r, 6'b010011);
  endtask

  task automatic t_window();
    wr(8'd2, 8'hFF); wr(8'd3, 8'h81);
    chk("R9 no write", flash_hi, 9'h03C);
    rd("R9 no read", 8'd2, 0, 0);
    rd("R9 cfg intact", 8'd1, 1, 8'h00);
  endtask

  task automatic t_lock();
    wr(8'd1, 8'h80);
    rd("R8 cfg hidden", 8'd1, 0, 0);
    rd("R8 bank hidden", 8'd0, 0, 0);
    wr(8'd0, 8'h77); chk("R8 bank frozen", flash_hi, 9'h03C);
    wr(8'd1, 8'h01); chk("R8 cfg frozen", flash_hi, 9'h03C);
    do_reset();
    rd("R8 reset bank", 8'd0, 1, 8'h00);
    rd("R8 reset cfg", 8'd1, 1, 8'h40);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset(); t_bank(); t_a21(); t_blk5(); t_wp(); t_layout(); t_always(); t_window(); t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule